// File: doc/BRIEF.md
# Cache-Line Crossing Penalty Calculator

This block works out how many extra cycles an instruction loses because a fetch or a data transfer runs across a 32-byte cache line. A pipeline's timing model presents one request per cycle. Each request carries the instruction address, an instruction kind, a flag that marks the instruction just after a taken jump, and, for block transfers, a base address and a word count. The block returns a penalty of 0, 1 or 2 cycles and an error flag exactly one cycle later.

Instructions with an immediate operand pay one cycle when they directly follow a jump and sit at certain halfword slots near the end of a line. Block transfers pay one cycle for each line boundary that their span crosses. A store span that crosses more than two boundaries cannot occur on a correct pipeline, so the block flags it. The result is kept separate from any register-hazard stalls and is not reduced by them. The caller adds it to those stalls.

Top module: `line_cross_penalty`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `res_valid`, `res_penalty` and `res_error` are all 0. This holds even when `req_valid` is high during reset.
- R2: Each cycle in which `req_valid` is high produces exactly one cycle of `res_valid` high, on the next rising edge. A cycle with `req_valid` low produces no result. While `res_valid` is low, `res_penalty` and `res_error` are 0.
- R3: Kind 1 (16-bit immediate) with `req_after_jump` high gives penalty 1 when bits [4:1] of `req_pc` are 4'b1111. Otherwise it gives 0. Bit 0 of `req_pc` is ignored.
- R4: Kind 2 (32-bit immediate) with `req_after_jump` high gives penalty 1 when bits [4:1] of `req_pc` are 4'b1110. Otherwise it gives 0.
- R5: For kinds 1 and 2, the penalty is 0 whenever `req_after_jump` is low.
- R6: For kinds 3 (block store) and 4 (block load), the span covers bytes `blk_addr` through `blk_addr + 4*blk_count - 1`, computed without wrap in 33 bits. The penalty equals end line index minus start line index (address bits [32:5]) when that difference is 0, 1 or 2. `req_after_jump` has no effect.
- R7: Kind 3 raises `res_error` with penalty 0 when the line difference is more than 2, when the difference is negative, or when `blk_count` is 0. No other kind ever raises `res_error`.
- R8: Kind 4 with a line difference outside 0..2 gives penalty 0 and no error.
- R9: Kind 0 (plain) and the unused codes 5 to 7 always give penalty 0 and no error, whatever the other inputs are.
- R10: A span that runs past address 2^32-1 counts line crossings across the 2^32 boundary. For example, base 0xFFFFFFF0 with 8 words gives penalty 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 plain, 1 16-bit immediate, 2 32-bit immediate, 3 block store, 4 block load |
| req_pc | input | 32 | Instruction address |
| req_after_jump | input | 1 | Previous instruction was a taken jump |
| blk_addr | input | 32 | Base byte address of a block transfer |
| blk_count | input | 5 | Number of 4-byte words in a block transfer |
| res_valid | output | 1 | Result present, one cycle after the request |
| res_penalty | output | 2 | Extra cycles: 0, 1 or 2 |
| res_error | output | 1 | Illegal store span |

## Verification
The fetch-slot rule and the span rule both see every request, so in the same cycle both can be handed inputs that would trigger them. For example, a block request can arrive with `req_after_jump` high and `req_pc` at slot 0x1E, and an immediate request can arrive with a base address and count that span three lines. The bench drives such mixed requests back to back, with idle gaps between some of them. The scoreboard then expects the penalty of the rule that belongs to the kind and nothing from the other rule: no added cycle and no stray error flag.

// File: rtl/lcp_pkg.sv
package lcp_pkg;
  typedef enum logic [2:0] {
    K_PLAIN  = 3'd0,
    K_IMM16  = 3'd1,
    K_IMM32  = 3'd2,
    K_BLK_ST = 3'd3,
    K_BLK_LD = 3'd4
  } op_kind_e;
endpackage

// File: rtl/lcp_fetch_rule.sv
// One extra cycle when an immediate-carrying instruction lands on a
// line-end halfword slot directly after a taken jump.
module lcp_fetch_rule
  import lcp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int LINE_LOG2 = 5
) (
  input  logic [PC_W-1:0] pc,
  input  logic            after_jump,
  input  op_kind_e        kind,
  output logic            extra
);
  localparam int SLOT_W = LINE_LOG2 - 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = '1;
  localparam logic [SLOT_W-1:0] SLOT_PREV = SLOT_LAST - 1'b1;

  logic [SLOT_W-1:0] slot;
  assign slot = pc[LINE_LOG2-1:1];

  always_comb begin
    extra = 1'b0;
    if (after_jump) begin
      unique case (kind)
        K_IMM16: extra = (slot == SLOT_LAST);
        K_IMM32: extra = (slot == SLOT_PREV);
        default: extra = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lcp_span_rule.sv
// Counts cache-line boundaries crossed by a block transfer span.
module lcp_span_rule #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 5,
  parameter int LINE_LOG2 = 5,
  parameter int WORD_LOG2 = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  input  logic              is_store,
  output logic [1:0]        pen,
  output logic              err
);
  localparam int SPAN_W = ADDR_W + 1;
  localparam int IDX_W  = SPAN_W - LINE_LOG2;

  logic [SPAN_W-1:0] bytes;
  logic [SPAN_W-1:0] last_byte;
  logic [IDX_W-1:0]  first_line;
  logic [IDX_W-1:0]  delta;
  logic              too_far;

  assign bytes      = SPAN_W'(count) << WORD_LOG2;
  assign last_byte  = {1'b0, addr} + bytes - SPAN_W'(1);
  assign first_line = {1'b0, addr[ADDR_W-1:LINE_LOG2]};
  assign delta      = last_byte[SPAN_W-1:LINE_LOG2] - first_line;
  assign too_far    = (delta > IDX_W'(2));

  assign pen = too_far ? 2'd0 : delta[1:0];
  assign err = is_store && (too_far || (count == '0));
endmodule

// File: rtl/line_cross_penalty.sv
module line_cross_penalty
  import lcp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 5,
  parameter int LINE_LOG2 = 5,
  parameter int WORD_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic              req_after_jump,
  input  logic [ADDR_W-1:0] blk_addr,
  input  logic [CNT_W-1:0]  blk_count,
  output logic              res_valid,
  output logic [1:0]        res_penalty,
  output logic              res_error
);
  op_kind_e   kind;
  logic       fetch_extra;
  logic [1:0] span_pen;
  logic       span_err;
  logic [1:0] next_pen;
  logic       next_err;

  assign kind = op_kind_e'(req_kind);

  lcp_fetch_rule #(.PC_W(ADDR_W), .LINE_LOG2(LINE_LOG2)) u_fetch (
    .pc         (req_pc),
    .after_jump (req_after_jump),
    .kind       (kind),
    .extra      (fetch_extra)
  );

  lcp_span_rule #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .LINE_LOG2(LINE_LOG2), .WORD_LOG2(WORD_LOG2)
  ) u_span (
    .addr     (blk_addr),
    .count    (blk_count),
    .is_store (kind == K_BLK_ST),
    .pen      (span_pen),
    .err      (span_err)
  );

  always_comb begin
    next_pen = 2'd0;
    next_err = 1'b0;
    case (kind)
      K_IMM16, K_IMM32: next_pen = {1'b0, fetch_extra};
      K_BLK_ST: begin
        next_err = span_err;
        next_pen = span_err ? 2'd0 : span_pen;
      end
      K_BLK_LD: next_pen = span_pen;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_penalty <= 2'd0;
      res_error   <= 1'b0;
    end else begin
      res_valid   <= req_valid;
      res_penalty <= req_valid ? next_pen : 2'd0;
      res_error   <= req_valid ? next_err : 1'b0;
    end
  end

  // R2
  res_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  // R2
  no_spurious_res_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!res_valid && res_penalty == 2'd0 && !res_error));
  // R7
  err_pen_zero_chk: assert property (@(posedge clk) disable iff (rst)
    res_error |-> (res_penalty == 2'd0));
  // R7
  err_only_store_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != 3'd3) |=> !res_error);
  // R5
  nojump_imm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_after_jump && (req_kind == 3'd1 || req_kind == 3'd2))
    |=> (res_penalty == 2'd0));
  // R9
  plain_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_kind == 3'd0 || req_kind > 3'd4))
    |=> (res_penalty == 2'd0 && !res_error));
  // R3
  imm_pen_max_one_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_kind == 3'd1 || req_kind == 3'd2))
    |=> (res_penalty <= 2'd1));
  // R6
  pen_range_chk: assert property (@(posedge clk) disable iff (rst)
    res_penalty != 2'd3);
endmodule

// File: tb/line_cross_penalty_test.sv
module line_cross_penalty_test;
  typedef struct {
    logic [1:0] pen;
    logic       err;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [31:0] req_pc = 32'd0;
  logic        req_after_jump = 1'b0;
  logic [31:0] blk_addr = 32'd0;
  logic [4:0]  blk_count = 5'd0;
  logic        res_valid;
  logic [1:0]  res_penalty;
  logic        res_error;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  line_cross_penalty uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_pc(req_pc), .req_after_jump(req_after_jump),
    .blk_addr(blk_addr), .blk_count(blk_count),
    .res_valid(res_valid), .res_penalty(res_penalty), .res_error(res_error)
  );

  function automatic exp_t model(input logic [2:0] k, input logic [31:0] pc,
                                 input logic aj, input logic [31:0] a,
                                 input logic [4:0] n, input string tag);
    exp_t e;
    logic [63:0] last;
    logic [63:0] d;
    e.pen = 2'd0; e.err = 1'b0; e.tag = tag;
    last = {32'd0, a} + 64'(n) * 64'd4 - 64'd1;
    d = (last >> 5) - ({32'd0, a} >> 5);
    case (k)
      3'd1: if (aj && pc[4:1] == 4'hF) e.pen = 2'd1;
      3'd2: if (aj && pc[4:1] == 4'hE) e.pen = 2'd1;
      3'd3: begin
        if (d > 64'd2 || n == 5'd0) e.err = 1'b1;
        else e.pen = d[1:0];
      end
      3'd4: if (d <= 64'd2) e.pen = d[1:0];
      default: ;
    endcase
    return e;
  endfunction

  task automatic send(input logic [2:0] k, input logic [31:0] pc,
                      input logic aj, input logic [31:0] a,
                      input logic [4:0] n, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_pc = pc;
    req_after_jump = aj; blk_addr = a; blk_count = n;
    sb.push_back(model(k, pc, aj, a, n, tag));
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_kind = 3'd1; req_after_jump = 1'b1; req_pc = 32'h1E;
    end
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst) begin
        if (sb.size() > 0) begin
          exp_t e;
          e = sb.pop_front();
          checks++;
          if (!res_valid || res_penalty !== e.pen || res_error !== e.err) begin
            errors++;
            $display("FAIL %s: valid=%0b pen=%0d err=%0b expected valid=1 pen=%0d err=%0b",
                     e.tag, res_valid, res_penalty, res_error, e.pen, e.err);
          end
        end else begin
          checks++;
          if (res_valid !== 1'b0 || res_penalty !== 2'd0 || res_error !== 1'b0) begin
            errors++;
            $display("FAIL R2: idle valid=%0b pen=%0d err=%0b expected 0 0 0",
                     res_valid, res_penalty, res_error);
          end
        end
      end
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: request held high during reset must not surface
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd1; req_after_jump = 1'b1; req_pc = 32'h1E;
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_penalty !== 2'd0 || res_error !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%0b pen=%0d err=%0b expected 0 0 0",
               res_valid, res_penalty, res_error);
    end
    req_valid = 1'b0;
    rst = 1'b0;
    @(posedge clk); #2;
    checks++;
    if (res_valid !== 1'b0 || res_penalty !== 2'd0 || res_error !== 1'b0) begin
      errors++;
      $display("FAIL R1: after reset valid=%0b pen=%0d err=%0b expected 0 0 0",
               res_valid, res_penalty, res_error);
    end

    // R3 16-bit immediate slots
    send(3'd1, 32'h0000_001E, 1'b1, 32'h0, 5'd0, "R3");
    send(3'd1, 32'h0000_001F, 1'b1, 32'h0, 5'd0, "R3");
    send(3'd1, 32'h1234_563E, 1'b1, 32'h0, 5'd0, "R3");
    send(3'd1, 32'h0000_001C, 1'b1, 32'h0, 5'd0, "R3");
    idle(2);
    // R4 32-bit immediate slots
    send(3'd2, 32'h0000_001C, 1'b1, 32'h0, 5'd0, "R4");
    send(3'd2, 32'h0000_001D, 1'b1, 32'h0, 5'd0, "R4");
    send(3'd2, 32'h0000_001E, 1'b1, 32'h0, 5'd0, "R4");
    send(3'd2, 32'h0000_0010, 1'b1, 32'h0, 5'd0, "R4");
    // R5 no jump -> nothing, even with three-line span on the side
    send(3'd1, 32'h0000_001E, 1'b0, 32'h1C, 5'd31, "R5");
    send(3'd2, 32'h0000_003C, 1'b0, 32'h1C, 5'd31, "R5");
    idle(1);
    // R6 block spans, after_jump at a penalty slot must not matter
    send(3'd4, 32'h1E, 1'b1, 32'h0000_0000, 5'd8,  "R6");
    send(3'd4, 32'h1E, 1'b1, 32'h0000_0004, 5'd8,  "R6");
    send(3'd4, 32'h1E, 1'b1, 32'h0000_001C, 5'd16, "R6");
    send(3'd3, 32'h1E, 1'b1, 32'h0000_001C, 5'd16, "R6");
    send(3'd3, 32'h1E, 1'b0, 32'h0000_0040, 5'd1,  "R6");
    send(3'd3, 32'h1E, 1'b1, 32'h0000_003C, 5'd2,  "R6");
    idle(3);
    // R7 illegal store spans
    send(3'd3, 32'h0, 1'b0, 32'h0000_001C, 5'd31, "R7");
    send(3'd3, 32'h0, 1'b0, 32'h0000_0010, 5'd0,  "R7");
    send(3'd3, 32'h0, 1'b0, 32'h0000_0020, 5'd0,  "R7");
    // R8 same spans as load
    send(3'd4, 32'h0, 1'b0, 32'h0000_001C, 5'd31, "R8");
    send(3'd4, 32'h0, 1'b0, 32'h0000_0000, 5'd0,  "R8");
    // R9 plain and unused kinds, with triggers on both rules
    send(3'd0, 32'h1E, 1'b1, 32'h1C, 5'd31, "R9");
    send(3'd5, 32'h1E, 1'b1, 32'h1C, 5'd31, "R9");
    send(3'd7, 32'h1C, 1'b1, 32'h1C, 5'd0,  "R9");
    // R10 wrap past the top of the address space
    send(3'd4, 32'h0, 1'b0, 32'hFFFF_FFF0, 5'd8,  "R10");
    send(3'd3, 32'h0, 1'b0, 32'hFFFF_FFFC, 5'd16, "R10");
    send(3'd3, 32'h0, 1'b0, 32'hFFFF_FFE0, 5'd8,  "R10");
    // R2 sweep: every slot for both immediate kinds, back to back
    for (int s = 0; s < 32; s++) begin
      send(3'd1, 32'(s), 1'b1, 32'h0, 5'd0, "R3");
      send(3'd2, 32'(s), 1'b1, 32'h0, 5'd0, "R4");
    end
    // sweep of base offsets and counts
    for (int o = 0; o < 32; o += 4) begin
      for (int c = 1; c <= 16; c += 5) begin
        send(3'd4, 32'h0, 1'b0, 32'h100 + 32'(o), 5'(c), "R6");
      end
    end
    idle(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule